// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block owns the processor status word and the shadow copies that an exception handler relies on. When the core raises a general exception or an interrupt and the block accepts it, the block walks through a fixed, four-step entry: it saves the program counter and the status word into shadow registers, marks the status word as blocked and switched to the alternate register bank, logs a 12-bit event code (and, for a trap instruction, its 8-bit immediate), and finally issues a one-cycle fetch redirect to the handler vector.

For a return request, the block first copies the saved status word back into the live one. It then waits for the core to report that the single delay-slot instruction has finished, and then redirects fetch to the saved program counter. While the blocked bit is set, new requests are dropped and flagged, unless the multiple-exception enable input is high. The core may also load the status word directly while the block is idle.

Top module: `exc_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the saved PC, saved status, both event registers and the trap register read zero, busy, redirect and drop are low, and the status word equals SR_RST_BASE with bit BL_POS (28) and bit RB_POS (29) set.
- R2: A request is accepted in an idle cycle when status bit BL_POS is 0 or multi_en is 1. On the first clock edge after acceptance, the saved PC takes the PC presented with the request and the saved status takes the live status word.
- R3: On the second edge after acceptance, status bits BL_POS and RB_POS become 1 and all other status bits keep their values.
- R4: On the third edge after acceptance, the 12-bit code goes into the interrupt event register if exc_is_irq was 1, and into the general event register otherwise. The other event register is left unchanged.
- R5: On that same third edge, the trap register takes the 8-bit immediate only when exc_is_trap was 1 and exc_is_irq was 0. It never changes while busy is low.
- R6: In the fourth cycle after acceptance, redir_valid is high for exactly one cycle. redir_addr is vec_base + GEN_OFF (0x100) for a general exception and vec_base + IRQ_OFF (0x600) for an interrupt.
- R7: busy is high from the cycle after acceptance through the redirect cycle, and is low otherwise outside a return.
- R8: A request in an idle cycle with BL_POS set and multi_en low is ignored, and drop is high in that cycle. With multi_en high the same request is accepted.
- R9: Any request made while busy is high is ignored and raises drop in that cycle.
- R10: A return request accepted in an idle cycle copies the saved status into the status word on that edge. busy then stays high until slot_done is seen. In the following cycle, redir_valid is high with redir_addr equal to the saved PC.
- R11: When an accepted exception and a return request arrive in the same idle cycle, the exception wins and the return is ignored. A return request while busy is ignored.
- R12: sr_wr_valid loads sr_wr_data into the status word only in an idle cycle with no exception accepted and no return taken. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception or interrupt request |
| exc_is_irq | input | 1 | Request is an interrupt (1) or general exception (0) |
| exc_is_trap | input | 1 | General exception comes from a trap instruction |
| exc_code | input | 12 | Event code to log |
| exc_imm | input | 8 | Trap immediate |
| exc_pc | input | 32 | PC to save |
| multi_en | input | 1 | Allow acceptance while blocked |
| vec_base | input | 32 | Vector base address |
| rte_valid | input | 1 | Return-from-exception request |
| slot_done | input | 1 | Delay-slot instruction completed |
| sr_wr_valid | input | 1 | Direct status word load |
| sr_wr_data | input | 32 | Status word load value |
| sr_q | output | 32 | Live status word |
| spc_q | output | 32 | Saved PC |
| ssr_q | output | 32 | Saved status word |
| gen_evt_q | output | 12 | General exception event code |
| irq_evt_q | output | 12 | Interrupt event code |
| trap_imm_q | output | 8 | Trap immediate |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_addr | output | 32 | Fetch redirect target |
| busy | output | 1 | Entry or return sequence in progress |
| drop | output | 1 | Request ignored this cycle |

## Verification
The bench builds the block with its default parameters: blocked bit 28, bank bit 29, offsets 0x100 and 0x600, and a reset status base of 0xF0. These defaults make the reset status word blocked, so the very first request exercises the drop path. A return taken right after reset then clears the blocked bit from the zeroed saved status. The separate offsets let every redirect reveal whether an interrupt or a general exception was logged. Directed nested entries with multi_en, simultaneous exception and return requests, and a long random stretch with random slot completion reach the ordering and ignore cases.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
    localparam int unsigned XLEN   = 32;
    localparam int unsigned CODE_W = 12;
    localparam int unsigned IMM_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SAVE  = 3'd1,
        ST_MARK  = 3'd2,
        ST_LOG   = 3'd3,
        ST_JUMP  = 3'd4,
        ST_SLOT  = 3'd5,
        ST_RJUMP = 3'd6
    } exc_state_e;

    typedef struct packed {
        logic              is_irq;
        logic              is_trap;
        logic [CODE_W-1:0] code;
        logic [IMM_W-1:0]  imm;
        logic [XLEN-1:0]   pc;
    } exc_req_t;

    function automatic logic [XLEN-1:0] vector_addr(
        input logic [XLEN-1:0] base,
        input logic            is_irq,
        input logic [XLEN-1:0] gen_off,
        input logic [XLEN-1:0] irq_off
    );
        return base + (is_irq ? irq_off : gen_off);
    endfunction
endpackage

// File: rtl/exc_seq.sv
`timescale 1ns/1ps
module exc_seq
    import exc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 exc_valid,
    input  logic                 exc_is_irq,
    input  logic                 exc_is_trap,
    input  logic [CODE_W-1:0]    exc_code,
    input  logic [IMM_W-1:0]     exc_imm,
    input  logic [XLEN-1:0]      exc_pc,
    input  logic                 multi_en,
    input  logic                 rte_valid,
    input  logic                 slot_done,
    input  logic                 bl_now,
    output exc_state_e           state_q,
    output exc_req_t             pend_q,
    output logic                 accept,
    output logic                 rte_go,
    output logic                 drop
);
    logic       idle;
    exc_state_e state_d;

    always_comb begin
        idle   = (state_q == ST_IDLE);
        accept = exc_valid && idle && (!bl_now || multi_en);
        rte_go = rte_valid && idle && !accept;
        drop   = exc_valid && !accept;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)      state_d = ST_SAVE;
                else if (rte_go) state_d = ST_SLOT;
            end
            ST_SAVE:  state_d = ST_MARK;
            ST_MARK:  state_d = ST_LOG;
            ST_LOG:   state_d = ST_JUMP;
            ST_JUMP:  state_d = ST_IDLE;
            ST_SLOT:  if (slot_done) state_d = ST_RJUMP;
            ST_RJUMP: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                pend_q.is_irq  <= exc_is_irq;
                pend_q.is_trap <= exc_is_trap && !exc_is_irq;
                pend_q.code    <= exc_code;
                pend_q.imm     <= exc_imm;
                pend_q.pc      <= exc_pc;
            end
        end
    end
endmodule

// File: rtl/exc_state_regs.sv
`timescale 1ns/1ps
module exc_state_regs
    import exc_pkg::*;
#(
    parameter int unsigned    BL_POS      = 28,
    parameter int unsigned    RB_POS      = 29,
    parameter logic [XLEN-1:0] SR_RST_BASE = 32'h0000_00F0
) (
    input  logic            clk,
    input  logic            rst,
    input  exc_state_e      state_q,
    input  logic [XLEN-1:0] pend_pc,
    input  logic            rte_go,
    input  logic            wr_go,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] sr_q,
    output logic [XLEN-1:0] spc_q,
    output logic [XLEN-1:0] ssr_q
);
    logic [XLEN-1:0] mark_mask;

    for (genvar i = 0; i < XLEN; i++) begin : g_mask
        assign mark_mask[i] = (i == BL_POS) || (i == RB_POS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= SR_RST_BASE | mark_mask;
            spc_q <= '0;
            ssr_q <= '0;
        end else begin
            if (state_q == ST_SAVE) begin
                spc_q <= pend_pc;
                ssr_q <= sr_q;
            end
            if (state_q == ST_MARK) sr_q <= sr_q | mark_mask;
            else if (rte_go)        sr_q <= ssr_q;
            else if (wr_go)         sr_q <= wr_data;
        end
    end
endmodule

// File: rtl/exc_event_log.sv
`timescale 1ns/1ps
module exc_event_log
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  exc_state_e        state_q,
    input  exc_req_t          pend_q,
    output logic [CODE_W-1:0] gen_evt_q,
    output logic [CODE_W-1:0] irq_evt_q,
    output logic [IMM_W-1:0]  trap_imm_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gen_evt_q  <= '0;
            irq_evt_q  <= '0;
            trap_imm_q <= '0;
        end else if (state_q == ST_LOG) begin
            if (pend_q.is_irq) irq_evt_q <= pend_q.code;
            else               gen_evt_q <= pend_q.code;
            if (pend_q.is_trap) trap_imm_q <= pend_q.imm;
        end
    end
endmodule

// File: rtl/exc_ctrl.sv
`timescale 1ns/1ps
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int unsigned     BL_POS      = 28,
    parameter int unsigned     RB_POS      = 29,
    parameter logic [XLEN-1:0] GEN_OFF     = 32'h0000_0100,
    parameter logic [XLEN-1:0] IRQ_OFF     = 32'h0000_0600,
    parameter logic [XLEN-1:0] SR_RST_BASE = 32'h0000_00F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_valid,
    input  logic              exc_is_irq,
    input  logic              exc_is_trap,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [IMM_W-1:0]  exc_imm,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              multi_en,
    input  logic [XLEN-1:0]   vec_base,
    input  logic              rte_valid,
    input  logic              slot_done,
    input  logic              sr_wr_valid,
    input  logic [XLEN-1:0]   sr_wr_data,
    output logic [XLEN-1:0]   sr_q,
    output logic [XLEN-1:0]   spc_q,
    output logic [XLEN-1:0]   ssr_q,
    output logic [CODE_W-1:0] gen_evt_q,
    output logic [CODE_W-1:0] irq_evt_q,
    output logic [IMM_W-1:0]  trap_imm_q,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_addr,
    output logic              busy,
    output logic              drop
);
    exc_state_e state_q;
    exc_req_t   pend_q;
    logic       accept;
    logic       rte_go;
    logic       wr_go;

    exc_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .exc_valid   (exc_valid),
        .exc_is_irq  (exc_is_irq),
        .exc_is_trap (exc_is_trap),
        .exc_code    (exc_code),
        .exc_imm     (exc_imm),
        .exc_pc      (exc_pc),
        .multi_en    (multi_en),
        .rte_valid   (rte_valid),
        .slot_done   (slot_done),
        .bl_now      (sr_q[BL_POS]),
        .state_q     (state_q),
        .pend_q      (pend_q),
        .accept      (accept),
        .rte_go      (rte_go),
        .drop        (drop)
    );

    assign wr_go = sr_wr_valid && (state_q == ST_IDLE) && !accept && !rte_go;

    exc_state_regs #(
        .BL_POS      (BL_POS),
        .RB_POS      (RB_POS),
        .SR_RST_BASE (SR_RST_BASE)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .state_q (state_q),
        .pend_pc (pend_q.pc),
        .rte_go  (rte_go),
        .wr_go   (wr_go),
        .wr_data (sr_wr_data),
        .sr_q    (sr_q),
        .spc_q   (spc_q),
        .ssr_q   (ssr_q)
    );

    exc_event_log u_log (
        .clk        (clk),
        .rst        (rst),
        .state_q    (state_q),
        .pend_q     (pend_q),
        .gen_evt_q  (gen_evt_q),
        .irq_evt_q  (irq_evt_q),
        .trap_imm_q (trap_imm_q)
    );

    always_comb begin
        busy        = (state_q != ST_IDLE);
        redir_valid = (state_q == ST_JUMP) || (state_q == ST_RJUMP);
        if (state_q == ST_JUMP)
            redir_addr = vector_addr(vec_base, pend_q.is_irq, GEN_OFF, IRQ_OFF);
        else
            redir_addr = spc_q;
    end
endmodule

// File: rtl/exc_ctrl_chk.sv
`timescale 1ns/1ps
module exc_ctrl_chk
    import exc_pkg::*;
#(
    parameter int unsigned BL_POS = 28,
    parameter int unsigned RB_POS = 29
) (
    input logic              clk,
    input logic              rst,
    input logic              exc_valid,
    input logic [XLEN-1:0]   exc_pc,
    input logic              rte_valid,
    input logic [XLEN-1:0]   sr_q,
    input logic [XLEN-1:0]   spc_q,
    input logic [XLEN-1:0]   ssr_q,
    input logic [IMM_W-1:0]  trap_imm_q,
    input logic              redir_valid,
    input logic              busy,
    input logic              drop
);
    // R6
    redir_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !redir_valid);

    // R7
    redir_busy_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> busy);

    // R8
    drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (drop && !busy && !rte_valid) |=> !busy);

    // R5
    trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(trap_imm_q));

    // R10
    rte_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && rte_valid && !exc_valid) |=> (sr_q == $past(ssr_q)));

    // R2
    save_pc_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !$past(rte_valid)) |=> (spc_q == $past(exc_pc, 2)));

    // R3
    mark_bits_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !$past(rte_valid)) |=> ##1 (sr_q[BL_POS] && sr_q[RB_POS]));
endmodule

bind exc_ctrl exc_ctrl_chk #(.BL_POS(BL_POS), .RB_POS(RB_POS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .exc_valid   (exc_valid),
    .exc_pc      (exc_pc),
    .rte_valid   (rte_valid),
    .sr_q        (sr_q),
    .spc_q       (spc_q),
    .ssr_q       (ssr_q),
    .trap_imm_q  (trap_imm_q),
    .redir_valid (redir_valid),
    .busy        (busy),
    .drop        (drop)
);

// File: tb/exc_ctrl_bench.sv
`timescale 1ns/1ps
module exc_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 0, exc_is_irq = 0, exc_is_trap = 0;
    logic [11:0] exc_code = 0;
    logic [7:0]  exc_imm = 0;
    logic [31:0] exc_pc = 0;
    logic        multi_en = 0;
    logic [31:0] vec_base = 32'h8C00_0000;
    logic        rte_valid = 0, slot_done = 0, sr_wr_valid = 0;
    logic [31:0] sr_wr_data = 0;
    logic [31:0] sr_q, spc_q, ssr_q, redir_addr;
    logic [11:0] gen_evt_q, irq_evt_q;
    logic [7:0]  trap_imm_q;
    logic        redir_valid, busy, drop;

    always #2.5 clk = ~clk;

    exc_ctrl u_exc_ctrl (.*);

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference: phase 0 idle, 1..4 entry steps, 5 wait slot, 6 return jump
    int          m_phase;
    logic [31:0] m_sr, m_spc, m_ssr;
    logic [11:0] m_gen, m_irq;
    logic [7:0]  m_trap;
    logic        p_irq, p_trap;
    logic [11:0] p_code;
    logic [7:0]  p_imm;
    logic [31:0] p_pc;

    function automatic bit m_accept();
        return exc_valid && m_phase == 0 && (!m_sr[28] || multi_en);
    endfunction
    function automatic bit m_rte();
        return rte_valid && m_phase == 0 && !m_accept();
    endfunction

    task automatic model_reset();
        m_phase = 0; m_sr = 32'h3000_00F0; m_spc = 0; m_ssr = 0;
        m_gen = 0; m_irq = 0; m_trap = 0;
        p_irq = 0; p_trap = 0; p_code = 0; p_imm = 0; p_pc = 0;
    endtask

    task automatic model_edge();
        bit acc, rg;
        acc = m_accept();
        rg  = m_rte();
        case (m_phase)
            0: begin
                if (acc) begin
                    p_irq = exc_is_irq; p_trap = exc_is_trap && !exc_is_irq;
                    p_code = exc_code; p_imm = exc_imm; p_pc = exc_pc;
                    m_phase = 1;
                end else if (rg) begin
                    m_sr = m_ssr; m_phase = 5;
                end else if (sr_wr_valid) m_sr = sr_wr_data;
            end
            1: begin m_spc = p_pc; m_ssr = m_sr; m_phase = 2; end
            2: begin m_sr = m_sr | 32'h3000_0000; m_phase = 3; end
            3: begin
                if (p_irq) m_irq = p_code; else m_gen = p_code;
                if (p_trap) m_trap = p_imm;
                m_phase = 4;
            end
            4: m_phase = 0;
            5: if (slot_done) m_phase = 6;
            default: m_phase = 0;
        endcase
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [31:0] e_addr;
        e_addr = (m_phase == 4) ? vec_base + (p_irq ? 32'h600 : 32'h100) : m_spc;
        chk("R3 R10 R12 sr", sr_q, m_sr);
        chk("R2 spc", spc_q, m_spc);
        chk("R2 ssr", ssr_q, m_ssr);
        chk("R4 gen_evt", {20'd0, gen_evt_q}, {20'd0, m_gen});
        chk("R4 irq_evt", {20'd0, irq_evt_q}, {20'd0, m_irq});
        chk("R5 trap", {24'd0, trap_imm_q}, {24'd0, m_trap});
        chk("R6 R10 redir_valid", {31'd0, redir_valid}, {31'd0, (m_phase == 4 || m_phase == 6)});
        if (m_phase == 4 || m_phase == 6) chk("R6 R10 redir_addr", redir_addr, e_addr);
        chk("R7 R11 busy", {31'd0, busy}, {31'd0, m_phase != 0});
        chk("R8 R9 drop", {31'd0, drop}, {31'd0, exc_valid && !m_accept()});
    endtask

    // inputs are set just after an edge; compare settles 1 ns later
    task automatic step();
        #1;
        if (!rst) compare();
        @(posedge clk);
        if (rst) model_reset(); else model_edge();
        #1;
    endtask

    task automatic quiet();
        exc_valid = 0; exc_is_irq = 0; exc_is_trap = 0; rte_valid = 0;
        slot_done = 0; sr_wr_valid = 0;
    endtask

    task automatic req(bit irq, bit trap, logic [11:0] code, logic [7:0] imm, logic [31:0] pc);
        exc_valid = 1; exc_is_irq = irq; exc_is_trap = trap;
        exc_code = code; exc_imm = imm; exc_pc = pc;
        step();
        quiet();
    endtask

    task automatic idle_n(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_rte(int slot_wait);
        rte_valid = 1; step(); quiet();
        idle_n(slot_wait);
        slot_done = 1; step(); quiet();
        idle_n(2);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        model_reset();
        quiet();
        idle_n(3);
        rst = 0;
        // R1 reset values
        #1;
        chk("R1 sr reset", sr_q, 32'h3000_00F0);
        chk("R1 spc reset", spc_q, 0);
        chk("R1 busy reset", {29'd0, busy, redir_valid, drop}, 0);
        chk("R1 evt reset", {12'd0, gen_evt_q, irq_evt_q} | {24'd0, trap_imm_q}, 0);
        // R8 blocked after reset: dropped
        req(0, 0, 12'h0A0, 8'h00, 32'h0000_1000);
        idle_n(2);
        // R10 return from reset clears BL via zeroed saved status
        do_rte(2);
        // R12 direct status load
        sr_wr_valid = 1; sr_wr_data = 32'h0000_00F0; step(); quiet();
        // general exception, R9 and R11 during busy
        req(0, 0, 12'h1E0, 8'h33, 32'h0000_2000);
        exc_valid = 1; rte_valid = 1; sr_wr_valid = 1; sr_wr_data = 32'hFFFF_FFFF;
        step(); quiet();
        idle_n(4);
        do_rte(3);
        // interrupt
        req(1, 1, 12'h320, 8'h77, 32'h0000_3004);
        idle_n(5);
        do_rte(0);
        // trap
        req(0, 1, 12'h160, 8'h5A, 32'h0000_4008);
        idle_n(5);
        // R8 nested acceptance with multi_en while blocked
        multi_en = 1;
        req(1, 0, 12'h540, 8'h00, 32'h0000_5000);
        multi_en = 0;
        idle_n(5);
        do_rte(1);
        // R11 exception and return together
        sr_wr_valid = 1; sr_wr_data = 32'h0000_0010; step(); quiet();
        rte_valid = 1;
        req(0, 0, 12'h0C0, 8'h00, 32'h0000_6000);
        idle_n(5);
        do_rte(1);
        // random stretch
        for (int i = 0; i < 3000; i++) begin
            exc_valid   = ($urandom % 6) == 0;
            exc_is_irq  = $urandom % 2;
            exc_is_trap = $urandom % 2;
            exc_code    = 12'($urandom);
            exc_imm     = 8'($urandom);
            exc_pc      = $urandom;
            multi_en    = ($urandom % 4) == 0;
            rte_valid   = ($urandom % 5) == 0;
            slot_done   = ($urandom % 3) == 0;
            sr_wr_valid = ($urandom % 8) == 0;
            sr_wr_data  = $urandom;
            vec_base    = {$urandom % 16, 28'h000_0000} | 32'h0C00_0000;
            step();
        end
        quiet();
        idle_n(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule